// File: doc/BRIEF.md
# Four-Channel Bus-Master DMA Controller

This block moves data for up to four peripherals without CPU involvement. A peripheral raises its request line. The controller then asks the CPU for the system bus with a hold request. Once the hold acknowledge comes back, it drives a 16-bit memory address and the matching memory and I/O strobes for one transfer. It then gives the bus back. When copy mode is enabled, a request on channel 0 starts a memory-to-memory copy. Channel 0's address is the source and channel 1's address is the destination. The copy keeps the bus until channel 1's count runs out or an external end-of-process arrives.

While the bus belongs to the CPU, the CPU programs the controller through an 8-bit register port. Each channel holds a base and a current address and word count. The 16-bit values go through the port one byte at a time, low byte first. An internal byte pointer selects the byte, and a command resets the pointer. During each bus cycle, the upper address byte appears on the data pins together with a capture strobe for an external latch. The lower byte appears on dedicated pins.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, hrq_o is 0, all dack_no bits are 1, aen_o, adstb_o and eop_o are 0, all four bus strobes are high, and the status register (reg 0xB) reads 0.
- R2: Register addresses 2*c and 2*c+1 give the address and word count of channel c. A write loads both the base and current copies. A read returns the current value. Each access moves a byte pointer that selects the low byte and then the high byte. A write to 0xA resets the pointer to the low byte.
- R3: A pending request sets hrq_o in the next cycle. aen_o, adstb_o, dack_no and the bus strobes stay inactive until hlda_i has been sampled high.
- R4: When several requests are pending, the lowest-numbered channel is served.
- R5: The first granted cycle shows adstb_o=1, data_o set to address[15:8] and adr_lo_o set to address[7:0]. In the next cycle the served channel's dack_no bit goes low. Mode type 01 (bits [3:2] of a reg 0x9 write) drives ior_no and memw_no low. Type 10 drives memr_no and iow_no low.
- R6: After each transfer the current address moves by one, down when mode bit 5 is set and up otherwise, wrapping within 16 bits. The word count decrements by one.
- R7: A word count of N-1 gives N transfers. The transfer made with a count of 0 pulses eop_o and sets status bit c. The count then reads 0xFFFF. Reading the status register clears all of its terminal-count bits. Status bits [7:4] show the request inputs.
- R8: When mode bit 4 (auto-initialize) is set, the end of a transfer reloads the current address and count from their base values.
- R9: When reg 0x8 bit 0 is set, a request on channel 0 starts a copy. Each word takes four cycles: address, memory read at channel 0's address, address, and memory write at channel 1's address. The write cycle drives out the byte read. No dack_no bit goes low during a copy. The copy ends after channel 1's terminal count.
- R10: If eop_ni is sampled low in a copy's write cycle, the copy stops after that word and the bus is released.
- R11: Register writes made while aen_o is high are ignored and do not move the byte pointer.
- R12: Outside copy mode, each grant performs exactly one transfer, and hrq_o drops in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Register port select, active low |
| rd_ni | input | 1 | Register read strobe, active low |
| wr_ni | input | 1 | Register write strobe, active low |
| reg_addr_i | input | 4 | Register select |
| data_i | input | 8 | Data in (register writes, copy read data) |
| data_o | output | 8 | Data out (register reads, high address byte, copy write data) |
| data_oe_o | output | 1 | Enable for data_o |
| dreq_i | input | 4 | Per-channel service requests |
| dack_no | output | 4 | Per-channel acknowledge, active low |
| hrq_o | output | 1 | Bus hold request |
| hlda_i | input | 1 | Bus hold acknowledge |
| eop_ni | input | 1 | External end-of-process, active low |
| eop_o | output | 1 | Terminal-count pulse |
| adr_lo_o | output | 8 | Low address byte |
| adstb_o | output | 1 | High-address latch strobe |
| aen_o | output | 1 | Controller owns the bus |
| memr_no | output | 1 | Memory read strobe, active low |
| memw_no | output | 1 | Memory write strobe, active low |
| ior_no | output | 1 | I/O read strobe, active low |
| iow_no | output | 1 | I/O write strobe, active low |

## Verification
The assertions check the bus-ownership rules on every cycle:
- aen_o rises only after hlda_i was high.
- At most one acknowledge is active, and only while the bus is owned.
- The latch strobe lasts a single cycle.
- Memory read and write never overlap.
- eop_o appears only inside a data cycle.
- A single-mode grant ends after one transfer.
- The count wraps from zero to all-ones, and the address moves by exactly one.

Only the directed scenarios can show the values these rules leave open: the address bytes on the pins, which channel wins, the register values after terminal count and auto-initialize, the copied data, and a register write being ignored while the bus is owned.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_ADR, ST_XFER, ST_ADR2, ST_XFER2
  } st_e;

  typedef enum logic [1:0] {
    XT_VERIFY  = 2'b00,
    XT_TOMEM   = 2'b01,
    XT_FROMMEM = 2'b10,
    XT_RSVD    = 2'b11
  } xt_e;

  typedef struct packed {
    logic dec;
    logic autoi;
    xt_e  xt;
  } mode_t;

  localparam logic [3:0] RA_CMD    = 4'h8;
  localparam logic [3:0] RA_MODE   = 4'h9;
  localparam logic [3:0] RA_CLRPTR = 4'hA;
  localparam logic [3:0] RA_STAT   = 4'hB;
endpackage

// File: rtl/dma4_prio.sv
module dma4_prio #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req_i,
  output logic           any_o,
  output logic [CW-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (req_i[i]) idx_o = CW'(i);
  end
  assign any_o = |req_i;

  logic [NCH-1:0] lower_mask;
  assign lower_mask = (NCH'(1) << idx_o) - NCH'(1);

  // R4
  always_comb begin
    if (any_o) begin
      prio_pick_chk: assert (req_i[idx_o] && ((req_i & lower_mask) == '0));
    end
  end
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_addr_i,
  input  logic          wr_cnt_i,
  input  logic          hi_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          mode_we_i,
  input  mode_t         mode_i,
  input  logic          step_addr_i,
  input  logic          step_cnt_i,
  input  logic          reload_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] cnt_o,
  output logic          autoi_o,
  output xt_e           xt_o
);
  logic [AW-1:0] base_a_q, base_c_q, cur_a_q, cur_c_q;
  mode_t         mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_a_q <= '0;
      base_c_q <= '0;
      cur_a_q  <= '0;
      cur_c_q  <= '0;
      mode_q   <= '0;
    end else begin
      if (mode_we_i) mode_q <= mode_i;
      if (wr_addr_i) begin
        if (hi_i) begin
          base_a_q[AW-1:DW] <= wdata_i;
          cur_a_q[AW-1:DW]  <= wdata_i;
        end else begin
          base_a_q[DW-1:0] <= wdata_i;
          cur_a_q[DW-1:0]  <= wdata_i;
        end
      end
      if (wr_cnt_i) begin
        if (hi_i) begin
          base_c_q[AW-1:DW] <= wdata_i;
          cur_c_q[AW-1:DW]  <= wdata_i;
        end else begin
          base_c_q[DW-1:0] <= wdata_i;
          cur_c_q[DW-1:0]  <= wdata_i;
        end
      end
      if (reload_i) begin
        cur_a_q <= base_a_q;
        cur_c_q <= base_c_q;
      end else begin
        if (step_addr_i) cur_a_q <= mode_q.dec ? cur_a_q - AW'(1) : cur_a_q + AW'(1);
        if (step_cnt_i)  cur_c_q <= cur_c_q - AW'(1);
      end
    end
  end

  assign addr_o  = cur_a_q;
  assign cnt_o   = cur_c_q;
  assign autoi_o = mode_q.autoi;
  assign xt_o    = mode_q.xt;

  // R7
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_cnt_i && !reload_i && !wr_cnt_i && cur_c_q == '0) |=> cur_c_q == '1);

  // R6
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_addr_i && !reload_i && !wr_addr_i) |=>
      (AW'(cur_a_q - $past(cur_a_q)) == AW'(1) || AW'($past(cur_a_q) - cur_a_q) == AW'(1)));
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int AW = 2 * DW,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           rd_ni,
  input  logic           wr_ni,
  input  logic [3:0]     reg_addr_i,
  input  logic [DW-1:0]  data_i,
  output logic [DW-1:0]  data_o,
  output logic           data_oe_o,
  input  logic [NCH-1:0] dreq_i,
  output logic [NCH-1:0] dack_no,
  output logic           hrq_o,
  input  logic           hlda_i,
  input  logic           eop_ni,
  output logic           eop_o,
  output logic [DW-1:0]  adr_lo_o,
  output logic           adstb_o,
  output logic           aen_o,
  output logic           memr_no,
  output logic           memw_no,
  output logic           ior_no,
  output logic           iow_no
);
  st_e            st_q;
  logic [CW-1:0]  ch_q;
  logic           copy_q, copy_en_q, ptr_q;
  logic [NCH-1:0] tc_q;
  logic [DW-1:0]  tmp_q;

  logic [AW-1:0]  ch_addr [NCH];
  logic [AW-1:0]  ch_cnt  [NCH];
  logic [NCH-1:0] ch_auto;
  xt_e            ch_xt   [NCH];

  logic           any_req;
  logic [CW-1:0]  win;

  dma4_prio #(.NCH(NCH)) u_prio (.req_i(dreq_i), .any_o(any_req), .idx_o(win));

  // slave port: only while the CPU owns the bus
  logic          slave_ok, wr_acc, rd_acc, is_chreg, rsel;
  logic [CW-1:0] rch;
  assign slave_ok = (st_q == ST_IDLE) || (st_q == ST_HOLD);
  assign wr_acc   = slave_ok && !cs_ni && !wr_ni;
  assign rd_acc   = slave_ok && !cs_ni && !rd_ni && wr_ni;
  assign is_chreg = reg_addr_i < 4'(2 * NCH);
  assign rch      = reg_addr_i[CW:1];
  assign rsel     = reg_addr_i[0];

  logic [NCH-1:0] step_a, step_c, reload;
  logic           tc_hit, end_ev;
  logic [CW-1:0]  tc_ch;

  always_comb begin
    step_a = '0;
    step_c = '0;
    reload = '0;
    tc_hit = 1'b0;
    end_ev = 1'b0;
    tc_ch  = ch_q;
    if (st_q == ST_XFER) begin
      if (copy_q) begin
        step_a[0] = 1'b1;
      end else begin
        step_a[ch_q] = 1'b1;
        step_c[ch_q] = 1'b1;
        tc_hit = ch_cnt[ch_q] == '0;
        end_ev = tc_hit || !eop_ni;
        reload[ch_q] = end_ev && ch_auto[ch_q];
      end
    end else if (st_q == ST_XFER2) begin
      tc_ch     = CW'(1);
      step_a[1] = 1'b1;
      step_c[1] = 1'b1;
      tc_hit    = ch_cnt[1] == '0;
      end_ev    = tc_hit || !eop_ni;
      reload[0] = end_ev && ch_auto[0];
      reload[1] = end_ev && ch_auto[1];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma4_chan #(.AW(AW), .DW(DW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_addr_i  (wr_acc && is_chreg && rch == CW'(i) && !rsel),
      .wr_cnt_i   (wr_acc && is_chreg && rch == CW'(i) && rsel),
      .hi_i       (ptr_q),
      .wdata_i    (data_i),
      .mode_we_i  (wr_acc && reg_addr_i == RA_MODE && data_i[CW-1:0] == CW'(i)),
      .mode_i     (mode_t'(data_i[5:2])),
      .step_addr_i(step_a[i]),
      .step_cnt_i (step_c[i]),
      .reload_i   (reload[i]),
      .addr_o     (ch_addr[i]),
      .cnt_o      (ch_cnt[i]),
      .autoi_o    (ch_auto[i]),
      .xt_o       (ch_xt[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ch_q      <= '0;
      copy_q    <= 1'b0;
      copy_en_q <= 1'b0;
      ptr_q     <= 1'b0;
      tc_q      <= '0;
      tmp_q     <= '0;
    end else begin
      if (wr_acc && reg_addr_i == RA_CMD) copy_en_q <= data_i[0];
      if (wr_acc && reg_addr_i == RA_CLRPTR) ptr_q <= 1'b0;
      else if ((wr_acc || rd_acc) && is_chreg) ptr_q <= !ptr_q;
      if (rd_acc && reg_addr_i == RA_STAT) tc_q <= '0;
      else if (tc_hit) tc_q[tc_ch] <= 1'b1;
      if (st_q == ST_XFER && copy_q) tmp_q <= data_i;
      unique case (st_q)
        ST_IDLE:  if (any_req) st_q <= ST_HOLD;
        ST_HOLD:  if (hlda_i) begin
                    if (any_req) begin
                      st_q   <= ST_ADR;
                      ch_q   <= win;
                      copy_q <= copy_en_q && win == '0;
                    end else st_q <= ST_IDLE;
                  end
        ST_ADR:   st_q <= ST_XFER;
        ST_XFER:  st_q <= copy_q ? ST_ADR2 : ST_IDLE;
        ST_ADR2:  st_q <= ST_XFER2;
        ST_XFER2: st_q <= end_ev ? ST_IDLE : ST_ADR;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  logic [CW-1:0] bus_ch;
  logic [AW-1:0] bus_addr, reg_val;
  logic [DW-1:0] rd_data;
  logic          xfer1;

  assign xfer1    = st_q == ST_XFER && !copy_q;
  assign bus_ch   = (st_q == ST_ADR2 || st_q == ST_XFER2) ? CW'(1) : ch_q;
  assign bus_addr = ch_addr[bus_ch];
  assign reg_val  = rsel ? ch_cnt[rch] : ch_addr[rch];

  always_comb begin
    rd_data = '0;
    if (is_chreg) rd_data = ptr_q ? reg_val[AW-1:DW] : reg_val[DW-1:0];
    else if (reg_addr_i == RA_STAT) rd_data = DW'({dreq_i, tc_q});
  end

  assign hrq_o     = st_q != ST_IDLE;
  assign aen_o     = !slave_ok;
  assign adstb_o   = st_q == ST_ADR || st_q == ST_ADR2;
  assign adr_lo_o  = aen_o ? bus_addr[DW-1:0] : '0;
  assign data_o    = adstb_o ? bus_addr[AW-1:DW] : (st_q == ST_XFER2) ? tmp_q : rd_data;
  assign data_oe_o = adstb_o || st_q == ST_XFER2 || rd_acc;
  assign eop_o     = tc_hit;

  always_comb begin
    dack_no = '1;
    if (xfer1) dack_no[ch_q] = 1'b0;
  end

  assign memr_no = !((xfer1 && ch_xt[ch_q] == XT_FROMMEM) || (st_q == ST_XFER && copy_q));
  assign memw_no = !((xfer1 && ch_xt[ch_q] == XT_TOMEM) || st_q == ST_XFER2);
  assign ior_no  = !(xfer1 && ch_xt[ch_q] == XT_TOMEM);
  assign iow_no  = !(xfer1 && ch_xt[ch_q] == XT_FROMMEM);

  // R3
  bus_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aen_o) |-> $past(hlda_i));

  // R5
  dack_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dack_no));

  // R5
  dack_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_no != '1) |-> (aen_o && !adstb_o));

  // R5
  adstb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adstb_o |=> !adstb_o);

  // R9
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (memr_no || memw_no));

  // R7
  eop_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> (aen_o && !adstb_o));

  // R12
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer1 |=> !aen_o && !hrq_o);
endmodule

// File: tb/dma4_ctrl_test.sv
module dma4_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] reg_addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       doe;
  logic [3:0] dreq = '0;
  logic [3:0] dack_n;
  logic       hrq, hlda = 1'b0, eop_n = 1'b1, eop;
  logic [7:0] adr_lo;
  logic       adstb, aen, memr_n, memw_n, ior_n, iow_n;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma4_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .reg_addr_i(reg_addr), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .dreq_i(dreq), .dack_no(dack_n), .hrq_o(hrq), .hlda_i(hlda),
    .eop_ni(eop_n), .eop_o(eop), .adr_lo_o(adr_lo), .adstb_o(adstb),
    .aen_o(aen), .memr_no(memr_n), .memw_no(memw_n), .ior_no(ior_n), .iow_no(iow_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; reg_addr = a; din = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cs_n = 0; rd_n = 0; reg_addr = a;
    #1 d = dout;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    reg_wr(4'hA, 8'h00);
    reg_wr(a, v[7:0]);
    reg_wr(a, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    reg_wr(4'hA, 8'h00);
    reg_rd(a, lo);
    reg_rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic set_mode(input int ch, input logic [1:0] xt, input bit ai, input bit dec);
    reg_wr(4'h9, {2'b00, dec, ai, xt, 2'(ch)});
  endtask

  // observations from the last service
  logic [7:0] o_hi, o_lo;
  logic       o_stb, o_eop, o_hrq;
  logic [3:0] o_dack, o_strb;

  task automatic service(input logic [3:0] mask, input int wait_cyc, input bit intrude);
    @(negedge clk); dreq = mask;
    @(negedge clk);
    check("R3 hrq raised", hrq, 1);
    for (int k = 0; k < wait_cyc; k++) begin
      check("R3 no bus before hlda", {aen, adstb, dack_n, memr_n, memw_n, ior_n, iow_n},
            {1'b0, 1'b0, 4'hF, 4'hF});
      @(negedge clk);
    end
    hlda = 1;
    @(negedge clk);
    o_hi = dout; o_lo = adr_lo; o_stb = adstb;
    if (intrude) begin cs_n = 0; wr_n = 0; reg_addr = 4'h0; din = 8'hEE; end
    @(negedge clk);
    cs_n = 1; wr_n = 1;
    o_dack = dack_n; o_strb = {memr_n, memw_n, ior_n, iow_n}; o_eop = eop;
    dreq = '0;
    @(negedge clk);
    o_hrq = hrq;
    hlda = 0;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R1 hrq", hrq, 0);
    check("R1 dack", dack_n, 4'hF);
    check("R1 aen/adstb/eop", {aen, adstb, eop}, 0);
    check("R1 strobes", {memr_n, memw_n, ior_n, iow_n}, 4'hF);
    reg_rd(4'hB, s);
    check("R1 status", s, 0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr16(4'h4, 16'h3412);
    rd16(4'h4, v);
    check("R2 addr readback", v, 16'h3412);
    reg_wr(4'hA, 0);
    reg_wr(4'h4, 8'hAB);
    reg_wr(4'hA, 0);
    reg_wr(4'h4, 8'hCD);
    rd16(4'h4, v);
    check("R2 pointer clear", v, 16'h34CD);
    wr16(4'h5, 16'h0102);
    rd16(4'h5, v);
    check("R2 count readback", v, 16'h0102);
  endtask

  task automatic t_single();
    logic [15:0] v;
    set_mode(1, 2'b01, 0, 0);
    wr16(4'h2, 16'hA5C3);
    wr16(4'h3, 16'h0005);
    service(4'b0010, 0, 0);
    check("R5 high byte on data", o_hi, 8'hA5);
    check("R5 low byte", o_lo, 8'hC3);
    check("R5 adstb", o_stb, 1);
    check("R5 dack ch1", o_dack, 4'b1101);
    check("R5 type01 strobes", o_strb, 4'b1001);
    check("R7 no eop", o_eop, 0);
    check("R12 hrq dropped", o_hrq, 0);
    rd16(4'h2, v);
    check("R6 addr inc", v, 16'hA5C4);
    rd16(4'h3, v);
    check("R6 count dec", v, 16'h0004);
    set_mode(1, 2'b10, 0, 0);
    service(4'b0010, 0, 0);
    check("R5 type10 strobes", o_strb, 4'b0110);
    check("R5 next low byte", o_lo, 8'hC4);
  endtask

  task automatic t_prio();
    wr16(4'h7, 16'h0100);
    service(4'b1100, 0, 0);
    check("R4 ch2 over ch3", o_dack, 4'b1011);
    service(4'b1010, 0, 0);
    check("R4 ch1 over ch3", o_dack, 4'b1101);
  endtask

  task automatic t_hold();
    service(4'b0100, 4, 0);
    check("R3 served after hlda", o_dack, 4'b1011);
  endtask

  task automatic t_tc();
    logic [15:0] v;
    logic [7:0] s;
    set_mode(3, 2'b01, 0, 1);
    wr16(4'h6, 16'h0000);
    wr16(4'h7, 16'h0000);
    service(4'b1000, 0, 0);
    check("R7 eop at count 0", o_eop, 1);
    rd16(4'h6, v);
    check("R6 dec wrap", v, 16'hFFFF);
    rd16(4'h7, v);
    check("R7 count wraps", v, 16'hFFFF);
    reg_rd(4'hB, s);
    check("R7 status tc3", s, 8'h08);
    reg_rd(4'hB, s);
    check("R7 status cleared", s, 8'h00);
    set_mode(2, 2'b01, 0, 0);
    wr16(4'h4, 16'hFFFF);
    wr16(4'h5, 16'h0001);
    service(4'b0100, 0, 0);
    rd16(4'h4, v);
    check("R6 inc wrap", v, 16'h0000);
  endtask

  task automatic t_auto();
    logic [15:0] v;
    logic [7:0] s;
    set_mode(0, 2'b01, 1, 0);
    wr16(4'h0, 16'h0100);
    wr16(4'h1, 16'h0001);
    service(4'b0001, 0, 0);
    check("R8 first no eop", o_eop, 0);
    service(4'b0001, 0, 0);
    check("R8 second eop", o_eop, 1);
    rd16(4'h0, v);
    check("R8 addr reloaded", v, 16'h0100);
    rd16(4'h1, v);
    check("R8 count reloaded", v, 16'h0001);
    reg_rd(4'hB, s);
    check("R7 status tc0", s, 8'h01);
  endtask

  task automatic t_intrude();
    logic [15:0] v;
    service(4'b0010, 0, 1);
    rd16(4'h0, v);
    check("R11 write ignored while bus owned", v, 16'h0100);
  endtask

  task automatic run_copy(input logic [15:0] src, input logic [15:0] dst, input int words,
                          input int stop_at);
    @(negedge clk); dreq = 4'b0001;
    @(negedge clk);
    check("R9 hrq", hrq, 1);
    hlda = 1;
    for (int k = 0; k < words; k++) begin
      @(negedge clk);
      dreq = '0;
      check("R9 src address", {adstb, dout, adr_lo}, {1'b1, src + 16'(k)});
      @(negedge clk);
      check("R9 read cycle", {memr_n, memw_n, dack_n}, {2'b01, 4'hF});
      din = 8'h5A + 8'(k);
      @(negedge clk);
      check("R9 dst address", {adstb, dout, adr_lo}, {1'b1, dst + 16'(k)});
      @(negedge clk);
      check("R9 write data", {memr_n, memw_n, doe, dout}, {3'b101, 8'h5A + 8'(k)});
      if (stop_at < 0) check("R9 eop on last", eop, (k == words - 1) ? 1 : 0);
      if (k == stop_at) eop_n = 0;
    end
    @(negedge clk);
    eop_n = 1;
    check("R10/R9 bus released", {hrq, aen}, 2'b00);
    hlda = 0;
  endtask

  task automatic t_copy();
    logic [15:0] v;
    logic [7:0] s;
    reg_wr(4'h8, 8'h01);
    set_mode(0, 2'b01, 0, 0);
    set_mode(1, 2'b01, 0, 0);
    wr16(4'h0, 16'h1000);
    wr16(4'h2, 16'h2000);
    wr16(4'h3, 16'h0002);
    run_copy(16'h1000, 16'h2000, 3, -1);
    rd16(4'h0, v);
    check("R9 src advanced", v, 16'h1003);
    rd16(4'h2, v);
    check("R9 dst advanced", v, 16'h2003);
    rd16(4'h3, v);
    check("R9 count done", v, 16'hFFFF);
    reg_rd(4'hB, s);
    check("R9 status tc1", s, 8'h02);
  endtask

  task automatic t_eop();
    logic [15:0] v;
    wr16(4'h0, 16'h4000);
    wr16(4'h2, 16'h3000);
    wr16(4'h3, 16'h0005);
    run_copy(16'h4000, 16'h3000, 2, 1);
    rd16(4'h3, v);
    check("R10 count after early stop", v, 16'h0003);
    rd16(4'h2, v);
    check("R10 dst after early stop", v, 16'h3002);
    reg_wr(4'h8, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_single();
    t_prio();
    t_hold();
    t_tc();
    t_auto();
    t_intrude();
    t_copy();
    t_eop();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule